// File: doc/BRIEF.md
# Power-Up EPC Checksum Builder

After every reset this block fills in the checksum word of a tag's EPC memory bank. It reads the protocol-control word first. It takes the EPC word count from the top five bits of that word. It then reads exactly that many EPC words in ascending address order and runs all the covered bits through a CRC-16. Bits enter most significant first, starting with the protocol-control word. The ones complement of the final register is written back to the checksum slot.

The bank is reached through a single-port word interface with one cycle of read latency. While the walk is in progress, a host read aimed at the checksum word is held off with a stall flag. The `done` flag rises once the new checksum is in memory and stays high until the next reset.

Word layout of the bank: word 0 is the checksum, word 1 is the protocol-control word, and EPC words start at word 2.

Top module: `epc_crc_gen`

## Requirements
- R1: `done` is low during reset and throughout the walk. It rises in the cycle after the single checksum write and then stays high until reset.
- R2: The first memory read after reset targets word address 1, the protocol-control word.
- R3: The EPC length L is bits [15:11] of the protocol-control word. After the protocol-control read, the block reads word addresses 2 to 1+L once each, in ascending order. It never reads address 0 or any address above 1+L.
- R4: The checksum uses the polynomial x^16+x^12+x^5+1 with the register preset to FFFFh. Bits are fed most significant first: the protocol-control word, then the L EPC words.
- R5: The stored value is the ones complement of the register. Running the covered words followed by the stored word through the same CRC gives the residue 1D0Fh.
- R6: With L equal to 0, the checksum covers the protocol-control word alone.
- R7: Exactly one write happens per walk, and it goes to word address 0. There are no writes after `done`.
- R8: `host_stall` is high for a host read of address 0 while `done` is low. A host read of any other address is never stalled, and after `done` nothing is stalled.
- R9: The read enable and the write enable are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release starts the walk |
| mem_rd_en | output | 1 | Bank read request |
| mem_wr_en | output | 1 | Bank write request |
| mem_addr | output | ADDR_W | Bank word address for read or write |
| mem_rd_data | input | 16 | Read data, valid one cycle after `mem_rd_en` |
| mem_wr_data | output | 16 | Checksum word to store |
| host_rd_req | input | 1 | A host is trying to read the bank |
| host_rd_addr | input | ADDR_W | Word address of the host read |
| host_stall | output | 1 | Host read must wait |
| done | output | 1 | Checksum written |

## Verification
The bench builds the block with its defaults: a 6-bit word address and a 5-bit length field. With these values every legal EPC length, from 0 to 31 words, fits in a 64-word model bank. The sweep covers all 32 lengths under three data patterns, with unrelated bits in the lower protocol-control field and junk placed beyond the covered range. This exposes any error in length extraction, range bounds or bit order, both in the stored value and in the read address sequence.

// File: rtl/epc_crc_pkg.sv
package epc_crc_pkg;

    localparam int unsigned WORD_W = 16;
    localparam logic [WORD_W-1:0] CRC_POLY   = 16'h1021;
    localparam logic [WORD_W-1:0] CRC_PRESET = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_START,
        ST_ISSUE,
        ST_TAKE,
        ST_STORE,
        ST_FINISH
    } walk_state_e;

    // Advance the CRC register over one word, MSB first.
    function automatic logic [WORD_W-1:0] crc_step_word(
        input logic [WORD_W-1:0] crc_in,
        input logic [WORD_W-1:0] word
    );
        logic [WORD_W-1:0] acc;
        logic              fb;
        acc = crc_in;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            fb  = acc[WORD_W-1] ^ word[b];
            acc = {acc[WORD_W-2:0], 1'b0};
            if (fb) acc = acc ^ CRC_POLY;
        end
        return acc;
    endfunction

endpackage

// File: rtl/epc_crc_engine.sv
module epc_crc_engine
    import epc_crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [WORD_W-1:0] data,
    output logic [WORD_W-1:0] crc
);

    logic [WORD_W-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (upd) crc_d = crc_step_word(crc_q, data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_PRESET;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

endmodule

// File: rtl/epc_crc_walker.sv
module epc_crc_walker
    import epc_crc_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] rd_data,
    output logic              rd_en,
    output logic              wr_en,
    output logic [ADDR_W-1:0] addr,
    output logic              upd,
    output logic              done
);

    localparam int unsigned CNT_W     = LEN_W + 1;
    localparam int unsigned SUM_ADDR  = 0;
    localparam int unsigned CTRL_ADDR = 1;
    localparam int unsigned DATA_BASE = 2;

    typedef struct packed {
        walk_state_e       st;
        logic [CNT_W-1:0]  cnt;   // words already fed
        logic [LEN_W-1:0]  len;   // EPC words to cover
    } walk_t;

    walk_t s_d, s_q;
    logic [LEN_W-1:0] len_now;

    always_comb begin
        s_d     = s_q;
        rd_en   = 1'b0;
        wr_en   = 1'b0;
        upd     = 1'b0;
        done    = 1'b0;
        addr    = ADDR_W'(SUM_ADDR);
        len_now = (s_q.cnt == '0) ? rd_data[WORD_W-1 -: LEN_W] : s_q.len;
        unique case (s_q.st)
            ST_START: begin
                s_d.cnt = '0;
                s_d.st  = ST_ISSUE;
            end
            ST_ISSUE: begin
                rd_en = 1'b1;
                if (s_q.cnt == '0) addr = ADDR_W'(CTRL_ADDR);
                else addr = ADDR_W'(DATA_BASE - 1) + ADDR_W'(s_q.cnt);
                s_d.st = ST_TAKE;
            end
            ST_TAKE: begin
                upd     = 1'b1;
                s_d.len = len_now;
                if (s_q.cnt == CNT_W'(len_now)) begin
                    s_d.st = ST_STORE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    s_d.st  = ST_ISSUE;
                end
            end
            ST_STORE: begin
                wr_en  = 1'b1;
                addr   = ADDR_W'(SUM_ADDR);
                s_d.st = ST_FINISH;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
            default: s_d.st = ST_START;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_START, cnt: '0, len: '0};
        else        s_q <= s_d;
    end

endmodule

// File: rtl/epc_crc_gen.sv
module epc_crc_gen
    import epc_crc_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [15:0]       mem_rd_data,
    output logic [15:0]       mem_wr_data,
    input  logic              host_rd_req,
    input  logic [ADDR_W-1:0] host_rd_addr,
    output logic              host_stall,
    output logic              done
);

    logic              upd;
    logic [WORD_W-1:0] crc;

    epc_crc_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) walker_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_data (mem_rd_data),
        .rd_en   (mem_rd_en),
        .wr_en   (mem_wr_en),
        .addr    (mem_addr),
        .upd     (upd),
        .done    (done)
    );

    epc_crc_engine engine_i (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (upd),
        .data  (mem_rd_data),
        .crc   (crc)
    );

    assign mem_wr_data = ~crc;
    assign host_stall  = host_rd_req && (host_rd_addr == '0) && !done;

endmodule

// File: rtl/epc_crc_gen_chk.sv
module epc_crc_gen_chk #(
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              host_stall,
    input logic              done
);

    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en)); // R9
    AST_WRITE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> mem_addr == '0); // R7
    AST_NO_WRITE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_wr_en); // R7
    AST_READ_NOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> mem_addr != '0); // R3
    AST_DONE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> done); // R1
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R1
    AST_NO_STALL_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !host_stall); // R8

endmodule

bind epc_crc_gen epc_crc_gen_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .mem_addr   (mem_addr),
    .host_stall (host_stall),
    .done       (done)
);

// File: tb/epc_crc_gen_tb_top.sv
module epc_crc_gen_tb_top;

    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mem_rd_en, mem_wr_en;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0]       mem_rd_data = '0;
    logic [15:0]       mem_wr_data;
    logic              host_rd_req = 1'b0;
    logic [ADDR_W-1:0] host_rd_addr = '0;
    logic              host_stall, done;

    logic [15:0] bank [DEPTH];

    int n_cmp = 0, n_bad = 0, cycles = 0;
    int rd_count, rd_bad, wr_count, wr_bad, tim_bad;
    logic wr_prev, done_prev;

    always #10 clk = ~clk;  // 50 MHz

    epc_crc_gen #(.ADDR_W(ADDR_W), .LEN_W(5)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_rd_data(mem_rd_data), .mem_wr_data(mem_wr_data),
        .host_rd_req(host_rd_req), .host_rd_addr(host_rd_addr),
        .host_stall(host_stall), .done(done)
    );

    // Bank model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= bank[mem_addr];
        if (mem_wr_en) bank[mem_addr] <= mem_wr_data;
    end

    // Port monitor, sampled mid-cycle
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (mem_rd_en) begin
                if (int'(mem_addr) != 1 + rd_count) rd_bad++;
                rd_count++;
            end
            if (mem_wr_en) begin
                wr_count++;
                if (mem_addr != '0) wr_bad++;
            end
            if (done && !done_prev && !wr_prev) tim_bad++;
            if (wr_prev && !done) tim_bad++;
            if (done_prev && !done) tim_bad++;
            wr_prev   = mem_wr_en;
            done_prev = done;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c0, input logic [15:0] w);
        logic [15:0] c = c0;
        for (int k = 0; k < 16; k++) begin
            logic top = c[15] ^ w[15 - k];
            c = c << 1;
            if (top) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    function automatic logic [15:0] pattern(input int p, input int i, input int len);
        return 16'((p * 16'h9E37) ^ (i * 16'h1357) ^ (len << 3) ^ (p == 2 ? 16'hFFFF : 16'h0));
    endfunction

    task automatic run(input int len, input int p);
        logic [15:0] exp, res, pc;
        int t;
        pc = {len[4:0], 11'(pattern(p, 1, len))};
        rst_n = 1'b0;
        bank[0] = 16'hDEAD;
        bank[1] = pc;
        for (int i = 2; i < DEPTH; i++) bank[i] = pattern(p, i, len);
        rd_count = 0; rd_bad = 0; wr_count = 0; wr_bad = 0; tim_bad = 0;
        wr_prev = 1'b0; done_prev = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 done low in reset", int'(done), 0);
        rst_n = 1'b1;
        if (p == 0) begin
            host_rd_req = 1'b1; host_rd_addr = '0; #1;
            check("R8 stall on word 0 before done", int'(host_stall), 1);
            host_rd_addr = 6'd1; #1;
            check("R8 no stall on other word", int'(host_stall), 0);
            host_rd_req = 1'b0;
        end
        t = 0;
        while (!done && t < 200) begin
            @(negedge clk);
            t++;
        end
        check("R1 done reached", int'(done), 1);
        repeat (3) @(negedge clk);
        exp = 16'hFFFF;
        exp = ref_crc(exp, pc);
        for (int i = 0; i < len; i++) exp = ref_crc(exp, bank[2 + i]);
        res = ref_crc(exp, ~exp);
        exp = ~exp;
        check(len == 0 ? "R6 control-word-only checksum" : "R4 checksum value",
              int'(bank[0]), int'(exp));
        res = 16'hFFFF;
        res = ref_crc(res, pc);
        for (int i = 0; i < len; i++) res = ref_crc(res, bank[2 + i]);
        res = ref_crc(res, bank[0]);
        check("R5 residue", int'(res), 16'h1D0F);
        check("R2 R3 read order", rd_bad, 0);
        check("R3 read count", rd_count, len + 1);
        check("R7 single write", wr_count, 1);
        check("R7 write address", wr_bad, 0);
        check("R1 done timing", tim_bad, 0);
        if (p == 0) begin
            host_rd_req = 1'b1; host_rd_addr = '0; #1;
            check("R8 no stall after done", int'(host_stall), 0);
            host_rd_req = 1'b0;
        end
    endtask

    initial begin
        for (int p = 0; p < 3; p++)
            for (int len = 0; len < 32; len++)
                run(len, p);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule